// File: doc/BRIEF.md
# Packet Page Allocator

This block owns the small pool of fixed-size packet pages behind a network interface. A bitmap records which pages are in use. Three queues of page numbers sit alongside it: pages waiting to be sent, pages already sent that the host has not yet reclaimed, and pages that hold received frames. The host drives the block with byte-wide command writes. It allocates pages for outgoing frames, frees pages, queues pages for sending and removes received frames. The receive side asks for one page per incoming frame.

Moving frame data and serialising it onto the wire happen elsewhere. A one-cycle transmit-start strobe that carries the page number marks each send. If a host allocation finds the pool exhausted, it stays pending. The block grants it on its own as soon as a page comes free.

Top module: `ppa_page_alloc`

## Requirements
- R1: After reset the allocation result reads 0x00 and the allocation-done flag is low. All queue counts and the used count are 0. Both queue heads read 0x80 and no strobe is active.
- R2: A command takes effect when `cmd_valid_i` is high. The opcode is `cmd_i[7:5]`: 0 none, 1 allocate, 2 reset all, 3 pop receive head, 4 pop receive head and free its page, 5 free page `pkt_sel_i`, 6 queue page `pkt_sel_i` for sending, 7 clear the send and completion queues. Opcode 0 changes nothing.
- R3: An allocate command clears the allocation-done flag and then grants the lowest-numbered free page. On a grant the result reads that page number and the flag goes high in the cycle after the command. When no page is free the result reads 0x80.
- R4: While the result reads 0x80 after a failed allocate, the first cycle in which a page is free grants it to the host (result and flag update the next cycle). In that cycle the host is served ahead of a receive request.
- R5: A receive request takes the lowest page still free after any host grant and appends it to the receive queue. `rx_grant_o` and `rx_page_o` appear the next cycle. With no page free, `rx_drop_o` pulses the next cycle and no state changes.
- R6: Opcode 3 removes the receive head and leaves its page allocated. Opcode 4 removes the head and frees its page. On an empty receive queue both change nothing.
- R7: Opcode 5 frees the selected page. Opcode 6 appends the selected page to the send queue, and is ignored when that queue already holds NUM_PAGES entries.
- R8: While `tx_en_i` is high the send queue drains one page per cycle in queue order. Each drained page gives `tx_start_o` with `tx_page_o` in the following cycle.
- R9: With `auto_rel_i` high a drained page is freed at once. Otherwise it is appended to the completion queue if that queue is not full. `done_pop_i` removes the completion head.
- R10: `done_head_o` and `rx_head_o` read 0x80 when their queue is empty, and otherwise the head page number.
- R11: Opcode 2 frees every page, empties all three queues, sets the result to 0x00 and cancels any pending allocation. Opcode 7 empties only the send and completion queues and leaves pages allocated.
- R12: `used_count_o` equals the number of allocated pages, and `mem_size_o` reads NUM_PAGES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command byte strobe |
| cmd_i | input | 8 | Command byte, opcode in bits 7:5 |
| pkt_sel_i | input | PG_W | Page operand for free and queue-for-send |
| tx_en_i | input | 1 | Allows the send queue to drain |
| auto_rel_i | input | 1 | Free drained pages instead of recording them |
| done_pop_i | input | 1 | Remove the completion queue head |
| rx_req_i | input | 1 | Receive side requests a page |
| alloc_result_o | output | 8 | Last host allocation result, 0x80 on failure |
| alloc_done_o | output | 1 | Host allocation granted |
| rx_grant_o | output | 1 | Receive request granted |
| rx_drop_o | output | 1 | Receive request refused, frame dropped |
| rx_page_o | output | PG_W | Page granted to the receive side |
| tx_start_o | output | 1 | A page is being sent |
| tx_page_o | output | PG_W | Page being sent |
| done_head_o | output | 8 | Completion queue head or 0x80 |
| rx_head_o | output | 8 | Receive queue head or 0x80 |
| tx_count_o | output | CNT_W | Send queue occupancy |
| done_count_o | output | CNT_W | Completion queue occupancy |
| rx_count_o | output | CNT_W | Receive queue occupancy |
| used_count_o | output | CNT_W | Allocated page count |
| mem_size_o | output | CNT_W | Pool size |

## Verification
The hardest case to reach is a single cycle that carries a pending failed host allocation, a page release and a receive request at once. There the two allocators compete for one freed page. The stimulus fills the pool through a mix of receive grants and host allocations. It then makes an allocate fail, and in one cycle it frees a page while the receive side asks for one. The host must win the page and the frame must be dropped. Send-queue overflow and drain order are reached by queueing duplicate pages while sending is held off, then opening the gate.

// File: rtl/ppa_pkg.sv
package ppa_pkg;
  localparam int unsigned RES_W = 8;
  localparam logic [RES_W-1:0] NO_PAGE = 8'h80;

  typedef enum logic [2:0] {
    OP_NOP         = 3'd0,
    OP_ALLOC       = 3'd1,
    OP_RESET_ALL   = 3'd2,
    OP_RX_POP      = 3'd3,
    OP_RX_POP_FREE = 3'd4,
    OP_FREE        = 3'd5,
    OP_TX_PUSH     = 3'd6,
    OP_TX_RESET    = 3'd7
  } ppa_op_e;
endpackage

// File: rtl/ppa_low_free.sv
module ppa_low_free #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [N-1:0]  used_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!used_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ppa_page_queue.sv
module ppa_page_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 2,
  parameter int unsigned CW    = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] cnt_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [W-1:0]  mem_n [DEPTH];
  logic [CW-1:0] cnt_q, cnt_n;

  // head at slot 0, entries shift down on pop
  always_comb begin
    for (int i = 0; i < DEPTH; i++) mem_n[i] = mem_q[i];
    cnt_n = cnt_q;
    if (clr_i) begin
      cnt_n = '0;
    end else begin
      if (pop_i && cnt_q != '0) begin
        for (int i = 0; i < DEPTH - 1; i++) mem_n[i] = mem_q[i+1];
        cnt_n = cnt_q - 1'b1;
      end
      if (push_i && cnt_n < CW'(DEPTH)) begin
        for (int i = 0; i < DEPTH; i++)
          if (CW'(i) == cnt_n) mem_n[i] = din_i;
        cnt_n = cnt_n + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      cnt_q <= cnt_n;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_n[i];
    end
  end

  assign head_o  = mem_q[0];
  assign cnt_o   = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/ppa_page_alloc.sv
module ppa_page_alloc
  import ppa_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 4,
  localparam int unsigned PG_W  = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int unsigned CNT_W = $clog2(NUM_PAGES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_valid_i,
  input  logic [7:0]       cmd_i,
  input  logic [PG_W-1:0]  pkt_sel_i,
  input  logic             tx_en_i,
  input  logic             auto_rel_i,
  input  logic             done_pop_i,
  input  logic             rx_req_i,
  output logic [RES_W-1:0] alloc_result_o,
  output logic             alloc_done_o,
  output logic             rx_grant_o,
  output logic             rx_drop_o,
  output logic [PG_W-1:0]  rx_page_o,
  output logic             tx_start_o,
  output logic [PG_W-1:0]  tx_page_o,
  output logic [RES_W-1:0] done_head_o,
  output logic [RES_W-1:0] rx_head_o,
  output logic [CNT_W-1:0] tx_count_o,
  output logic [CNT_W-1:0] done_count_o,
  output logic [CNT_W-1:0] rx_count_o,
  output logic [CNT_W-1:0] used_count_o,
  output logic [CNT_W-1:0] mem_size_o
);
  function automatic logic [NUM_PAGES-1:0] page_bit(input logic [PG_W-1:0] idx);
    logic [NUM_PAGES-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  function automatic logic [CNT_W-1:0] pop_cnt(input logic [NUM_PAGES-1:0] v);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NUM_PAGES; i++) c = c + CNT_W'(v[i]);
    return c;
  endfunction

  ppa_op_e op;
  logic is_alloc, is_reset_all, is_rx_pop, is_rx_pop_free, is_free, is_tx_push, is_tx_reset;

  logic [NUM_PAGES-1:0] used_q, used_n, used_mid, used_host, free_mask;
  logic [RES_W-1:0]     result_q, result_n;
  logic                 done_flag_q, done_flag_n;
  logic                 pending, host_want, host_grant, rx_try, rx_ok, drain;
  logic                 fa, fb;
  logic [PG_W-1:0]      ia, ib;

  logic [PG_W-1:0]  tx_head, done_head, rx_head;
  logic [CNT_W-1:0] tx_cnt, done_cnt, rx_cnt;
  logic             tx_empty, tx_full, done_empty, done_full, rx_empty, rx_full;

  logic             tx_start_q, rx_grant_q, rx_drop_q;
  logic [PG_W-1:0]  tx_page_q, rx_page_q;

  assign op             = ppa_op_e'(cmd_i[7:5]);
  assign is_alloc       = cmd_valid_i && (op == OP_ALLOC);
  assign is_reset_all   = cmd_valid_i && (op == OP_RESET_ALL);
  assign is_rx_pop      = cmd_valid_i && (op == OP_RX_POP);
  assign is_rx_pop_free = cmd_valid_i && (op == OP_RX_POP_FREE);
  assign is_free        = cmd_valid_i && (op == OP_FREE);
  assign is_tx_push     = cmd_valid_i && (op == OP_TX_PUSH);
  assign is_tx_reset    = cmd_valid_i && (op == OP_TX_RESET);

  // queue clears pre-empt the drain in the same cycle
  assign drain = tx_en_i && !tx_empty && !is_reset_all && !is_tx_reset;

  always_comb begin
    free_mask = '0;
    if (is_free)                        free_mask = free_mask | page_bit(pkt_sel_i);
    if (is_rx_pop_free && !rx_empty)    free_mask = free_mask | page_bit(rx_head);
    if (drain && auto_rel_i)            free_mask = free_mask | page_bit(tx_head);
  end

  assign used_mid = used_q & ~free_mask;

  // host allocator sees pages freed this cycle; receive allocator sees host grant
  assign pending   = (result_q == NO_PAGE);
  assign host_want = !is_reset_all && (is_alloc || pending);

  ppa_low_free #(.N(NUM_PAGES), .IW(PG_W)) u_find_host (
    .used_i (used_mid),
    .found_o(fa),
    .idx_o  (ia)
  );

  assign host_grant = host_want && fa;
  assign used_host  = host_grant ? (used_mid | page_bit(ia)) : used_mid;

  ppa_low_free #(.N(NUM_PAGES), .IW(PG_W)) u_find_rx (
    .used_i (used_host),
    .found_o(fb),
    .idx_o  (ib)
  );

  assign rx_try = rx_req_i && !is_reset_all;
  assign rx_ok  = rx_try && fb;

  always_comb begin
    if (is_reset_all)  used_n = '0;
    else if (rx_ok)    used_n = used_host | page_bit(ib);
    else               used_n = used_host;
  end

  always_comb begin
    result_n    = result_q;
    done_flag_n = done_flag_q;
    if (is_reset_all) begin
      result_n = '0;
    end else if (host_grant) begin
      result_n    = RES_W'(ia);
      done_flag_n = 1'b1;
    end else if (is_alloc) begin
      result_n    = NO_PAGE;
      done_flag_n = 1'b0;
    end
  end

  ppa_page_queue #(.DEPTH(NUM_PAGES), .W(PG_W), .CW(CNT_W)) u_tx_q (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (is_reset_all || is_tx_reset),
    .push_i (is_tx_push && !tx_full),
    .pop_i  (drain),
    .din_i  (pkt_sel_i),
    .head_o (tx_head),
    .cnt_o  (tx_cnt),
    .empty_o(tx_empty),
    .full_o (tx_full)
  );

  ppa_page_queue #(.DEPTH(NUM_PAGES), .W(PG_W), .CW(CNT_W)) u_done_q (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (is_reset_all || is_tx_reset),
    .push_i (drain && !auto_rel_i && !done_full),
    .pop_i  (done_pop_i && !done_empty),
    .din_i  (tx_head),
    .head_o (done_head),
    .cnt_o  (done_cnt),
    .empty_o(done_empty),
    .full_o (done_full)
  );

  ppa_page_queue #(.DEPTH(NUM_PAGES), .W(PG_W), .CW(CNT_W)) u_rx_q (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (is_reset_all),
    .push_i (rx_ok),
    .pop_i  ((is_rx_pop || is_rx_pop_free) && !rx_empty),
    .din_i  (ib),
    .head_o (rx_head),
    .cnt_o  (rx_cnt),
    .empty_o(rx_empty),
    .full_o (rx_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q      <= '0;
      result_q    <= '0;
      done_flag_q <= 1'b0;
      tx_start_q  <= 1'b0;
      tx_page_q   <= '0;
      rx_grant_q  <= 1'b0;
      rx_drop_q   <= 1'b0;
      rx_page_q   <= '0;
    end else begin
      used_q      <= used_n;
      result_q    <= result_n;
      done_flag_q <= done_flag_n;
      tx_start_q  <= drain;
      tx_page_q   <= tx_head;
      rx_grant_q  <= rx_ok;
      rx_drop_q   <= rx_try && !fb;
      rx_page_q   <= ib;
    end
  end

  assign alloc_result_o = result_q;
  assign alloc_done_o   = done_flag_q;
  assign rx_grant_o     = rx_grant_q;
  assign rx_drop_o      = rx_drop_q;
  assign rx_page_o      = rx_page_q;
  assign tx_start_o     = tx_start_q;
  assign tx_page_o      = tx_page_q;
  assign done_head_o    = done_empty ? NO_PAGE : RES_W'(done_head);
  assign rx_head_o      = rx_empty ? NO_PAGE : RES_W'(rx_head);
  assign tx_count_o     = tx_cnt;
  assign done_count_o   = done_cnt;
  assign rx_count_o     = rx_cnt;
  assign used_count_o   = pop_cnt(used_q);
  assign mem_size_o     = CNT_W'(NUM_PAGES);
endmodule

// File: rtl/ppa_page_alloc_chk.sv
module ppa_page_alloc_chk
  import ppa_pkg::*;
#(
  parameter int unsigned NUM_PAGES = 4,
  localparam int unsigned PG_W  = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int unsigned CNT_W = $clog2(NUM_PAGES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [7:0]       cmd_i,
  input logic             tx_en_i,
  input logic             auto_rel_i,
  input logic             rx_req_i,
  input logic [RES_W-1:0] alloc_result_o,
  input logic             rx_grant_o,
  input logic             rx_drop_o,
  input logic             tx_start_o,
  input logic [RES_W-1:0] done_head_o,
  input logic [RES_W-1:0] rx_head_o,
  input logic [CNT_W-1:0] tx_count_o,
  input logic [CNT_W-1:0] done_count_o,
  input logic [CNT_W-1:0] rx_count_o,
  input logic [CNT_W-1:0] used_count_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_PAGES);
  logic auto_free_now;
  assign auto_free_now = tx_en_i && auto_rel_i && (tx_count_o != '0);

  a_r3_result_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_result_o == NO_PAGE) || (alloc_result_o < RES_W'(NUM_PAGES)));

  a_r3_alloc_fails_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i[7:5] == 3'd1 && used_count_o == FULL && !auto_free_now)
    |=> (alloc_result_o == NO_PAGE));

  a_r5_drop_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_req_i && !cmd_valid_i && used_count_o == FULL && !auto_free_now) |=> rx_drop_o);

  a_r5_grant_drop_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_grant_o && rx_drop_o));

  a_r7_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i[7:5] == 3'd6 && tx_count_o == FULL && !tx_en_i)
    |=> (tx_count_o == FULL));

  a_r8_send_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(tx_en_i));

  a_r10_rx_head_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count_o == '0) |-> (rx_head_o == NO_PAGE));

  a_r10_done_head_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_count_o == '0) |-> (done_head_o == NO_PAGE));

  a_r12_used_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    used_count_o <= FULL);
endmodule

bind ppa_page_alloc ppa_page_alloc_chk #(.NUM_PAGES(NUM_PAGES)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cmd_valid_i   (cmd_valid_i),
  .cmd_i         (cmd_i),
  .tx_en_i       (tx_en_i),
  .auto_rel_i    (auto_rel_i),
  .rx_req_i      (rx_req_i),
  .alloc_result_o(alloc_result_o),
  .rx_grant_o    (rx_grant_o),
  .rx_drop_o     (rx_drop_o),
  .tx_start_o    (tx_start_o),
  .done_head_o   (done_head_o),
  .rx_head_o     (rx_head_o),
  .tx_count_o    (tx_count_o),
  .done_count_o  (done_count_o),
  .rx_count_o    (rx_count_o),
  .used_count_o  (used_count_o)
);

// File: tb/ppa_page_alloc_tb.sv
module ppa_page_alloc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic [1:0] sel = 2'd0;
  logic       tx_en = 1'b0, auto_rel = 1'b0, done_pop = 1'b0, rx_req = 1'b0;
  logic [7:0] result, done_head, rx_head;
  logic       alloc_done, rx_grant, rx_drop, tx_start;
  logic [1:0] rx_page, tx_page;
  logic [2:0] tx_count, done_count, rx_count, used_count, mem_size;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  ppa_page_alloc #(.NUM_PAGES(4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .pkt_sel_i(sel), .tx_en_i(tx_en), .auto_rel_i(auto_rel), .done_pop_i(done_pop),
    .rx_req_i(rx_req), .alloc_result_o(result), .alloc_done_o(alloc_done),
    .rx_grant_o(rx_grant), .rx_drop_o(rx_drop), .rx_page_o(rx_page),
    .tx_start_o(tx_start), .tx_page_o(tx_page), .done_head_o(done_head),
    .rx_head_o(rx_head), .tx_count_o(tx_count), .done_count_o(done_count),
    .rx_count_o(rx_count), .used_count_o(used_count), .mem_size_o(mem_size)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // called at a negedge; applies for one posedge, returns at the next negedge
  task automatic step(input bit cv, input logic [2:0] op, input logic [1:0] pg, input bit rq);
    cmd_valid = cv;
    cmd = {op, 5'b0};
    sel = pg;
    rx_req = rq;
    @(negedge clk);
    cmd_valid = 1'b0;
    rx_req = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 result", result, 8'h00);
    chk("R1 done flag", alloc_done, 0);
    chk("R1 used", used_count, 0);
    chk("R1 counts", {tx_count, done_count, rx_count}, 0);
    chk("R1 rx head", rx_head, 8'h80);
    chk("R1 done head", done_head, 8'h80);
    chk("R1 strobes", {tx_start, rx_grant, rx_drop}, 0);
    chk("R12 mem size", mem_size, 4);
  endtask

  task automatic t_alloc_and_retry();
    for (int i = 0; i < 4; i++) begin
      step(1, 3'd1, 2'd0, 0);
      chk("R3 lowest page", result, i);
      chk("R3 done flag", alloc_done, 1);
    end
    chk("R12 used full", used_count, 4);
    step(1, 3'd1, 2'd0, 0);
    chk("R3 fail code", result, 8'h80);
    chk("R3 flag cleared", alloc_done, 0);
    step(1, 3'd5, 2'd2, 0);
    chk("R4 retry grant", result, 2);
    chk("R4 retry flag", alloc_done, 1);
    chk("R7 R4 used after free+retry", used_count, 4);
  endtask

  task automatic t_rx_path();
    step(1, 3'd2, 2'd0, 0);
    chk("R11 reset used", used_count, 0);
    chk("R11 reset result", result, 0);
    step(0, 3'd0, 2'd0, 1);
    chk("R5 grant", rx_grant, 1);
    chk("R5 page", rx_page, 0);
    chk("R10 rx head", rx_head, 0);
    step(1, 3'd1, 2'd0, 0);
    chk("R3 after rx", result, 1);
    step(0, 3'd0, 2'd0, 1);
    chk("R5 second page", rx_page, 2);
    chk("R5 rx count", rx_count, 2);
    step(1, 3'd3, 2'd0, 0);
    chk("R6 pop head", rx_head, 2);
    chk("R6 pop keeps page", used_count, 3);
    step(1, 3'd4, 2'd0, 0);
    chk("R6 pop-free head", rx_head, 8'h80);
    chk("R6 pop-free used", used_count, 2);
    step(1, 3'd4, 2'd0, 0);
    chk("R6 empty pop-free used", used_count, 2);
    step(1, 3'd3, 2'd0, 0);
    chk("R6 empty pop count", rx_count, 0);
    step(0, 3'd0, 2'd0, 1);
    chk("R5 fill page", rx_page, 2);
    step(0, 3'd0, 2'd0, 1);
    chk("R5 fill page 3", rx_page, 3);
    step(0, 3'd0, 2'd0, 1);
    chk("R5 drop", rx_drop, 1);
    chk("R5 drop no grant", rx_grant, 0);
    chk("R5 drop rx count", rx_count, 2);
    chk("R5 drop used", used_count, 4);
    step(1, 3'd1, 2'd0, 0);
    chk("R3 full fail", result, 8'h80);
    step(1, 3'd5, 2'd1, 1);
    chk("R4 host first", result, 1);
    chk("R4 rx loses", rx_drop, 1);
    chk("R4 used", used_count, 4);
    step(1, 3'd0, 2'd3, 0);
    chk("R2 nop result", result, 1);
    chk("R2 nop used", used_count, 4);
    chk("R2 nop rx count", rx_count, 2);
  endtask

  task automatic t_tx_path();
    step(1, 3'd2, 2'd0, 0);
    for (int i = 0; i < 3; i++) step(1, 3'd1, 2'd0, 0);
    step(1, 3'd6, 2'd0, 0);
    step(1, 3'd6, 2'd2, 0);
    step(1, 3'd6, 2'd1, 0);
    step(1, 3'd6, 2'd0, 0);
    step(1, 3'd6, 2'd1, 0);
    chk("R7 full enqueue ignored", tx_count, 4);
    chk("R8 no send while disabled", tx_start, 0);
    tx_en = 1'b1;
    @(negedge clk); chk("R8 start", tx_start, 1); chk("R8 order 0", tx_page, 0);
    @(negedge clk); chk("R8 order 1", tx_page, 2);
    @(negedge clk); chk("R8 order 2", tx_page, 1);
    @(negedge clk); chk("R8 order 3", tx_page, 0);
    tx_en = 1'b0;
    chk("R8 drained", tx_count, 0);
    chk("R9 recorded", done_count, 4);
    chk("R9 done head", done_head, 0);
    @(negedge clk);
    chk("R8 stops", tx_start, 0);
    done_pop = 1'b1;
    @(negedge clk);
    done_pop = 1'b0;
    chk("R9 pop head", done_head, 2);
    chk("R9 pop count", done_count, 3);
    step(1, 3'd7, 2'd0, 0);
    chk("R11 tx reset done", done_count, 0);
    chk("R11 tx reset head", done_head, 8'h80);
    chk("R11 tx reset keeps pages", used_count, 3);
    auto_rel = 1'b1;
    step(1, 3'd6, 2'd1, 0);
    step(1, 3'd6, 2'd2, 0);
    tx_en = 1'b1;
    @(negedge clk); chk("R9 auto page a", tx_page, 1);
    @(negedge clk); chk("R9 auto page b", tx_page, 2);
    tx_en = 1'b0;
    chk("R9 auto freed", used_count, 1);
    chk("R9 auto not recorded", done_count, 0);
    auto_rel = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_alloc_and_retry();
    t_rx_path();
    t_tx_path();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule